// File: doc/BRIEF.md
# SPI Read-Command Master

This block is a single-slave SPI master. It runs SPI mode 0, 8-bit frames and a fixed clock divider. Frames to send enter through a transmit stream and wait in a TX FIFO. Captured frames wait in an RX FIFO until the consumer takes them. A 2-bit transfer mode selects one of four behaviours: full duplex, send only, receive only, or command-then-read. The command-then-read mode is meant for serial memories. It shifts out the opcode and address frames held in the TX FIFO and ignores the input line while it does so. When the TX FIFO runs dry, it keeps chip select low, holds the output line low, and clocks in a programmed number of read frames.

Software writes the mode and frame count while the block is disabled, loads the command frames, and raises the enable. A transfer starts when the block is enabled and the TX FIFO holds a frame. Chip select stays low across the whole transfer, so the memory sees the command and the read as one access. Changing the mode means disabling the block, and that releases chip select.

Both data interfaces are valid/ready streams. A TX frame is taken on a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low only while the TX FIFO is full. `rx_valid` is high while the RX FIFO holds a frame. A frame is removed on a cycle where `rx_valid` and `rx_ready` are both high. While `rx_ready` is low, `rx_valid` and `rx_data` hold. The serial side never waits for the consumer: a frame that finds the RX FIFO full is dropped.

Top module: `spi_rd_master`

## Requirements
- R1: `ctl_wr` loads `ctl_mode` and `ctl_count` only on a cycle where `ctl_en` is low. That same write clears the overflow flag. A `ctl_wr` while `ctl_en` is high has no effect on the running or any later transfer.
- R2: `spi_cs_n` is high whenever the block is idle or `ctl_en` is low. Lowering `ctl_en` in mid-transfer aborts the transfer. `spi_cs_n` is then high and `stat_busy` low at the next clock edge.
- R3: Mode 0 (duplex): each TX frame is shifted out MSB first and each received frame is pushed to the RX FIFO. The transfer ends at the first frame boundary where the TX FIFO is empty.
- R4: Mode 1 (send only): TX frames are shifted out as in mode 0. Nothing is pushed to the RX FIFO.
- R5: Mode 2 (receive only): one TX frame starts the transfer and is discarded without being shifted. Then `ctl_count`+1 frames are received and pushed, with `spi_dout` low throughout.
- R6: Mode 3 (command-then-read): TX frames are shifted out until the TX FIFO is empty, and `spi_din` is ignored during that phase. Then `ctl_count`+1 frames are received and pushed, with `spi_dout` held low.
- R7: `spi_cs_n` falls exactly once per transfer and stays low through both phases. It rises only after the last frame completes.
- R8: Serial timing is SPI mode 0. `spi_sclk` idles low. Each half period lasts HALF_DIV clocks. `spi_din` is sampled on the rising edge and `spi_dout` changes only on the falling edge. `spi_sclk` toggles only while `spi_cs_n` is low.
- R9: A frame completing while the RX FIFO is full is dropped and sets `stat_rx_ovf`. The flag stays set until an accepted control write.
- R10: `stat_busy` is high from the cycle `spi_cs_n` falls until the cycle it rises, and low otherwise.
- R11: After reset the RX stream is empty, `tx_ready` is high and the overflow flag is clear. `rx_valid` and `rx_data` hold while `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Block enable; low releases chip select |
| ctl_wr | input | 1 | Control write strobe, taken only while disabled |
| ctl_mode | input | 2 | Transfer mode: 0 duplex, 1 send only, 2 receive only, 3 command-then-read |
| ctl_count | input | CNT_W | Read frame count minus one |
| stat_busy | output | 1 | Transfer in progress |
| stat_rx_ovf | output | 1 | Sticky RX overflow flag |
| tx_valid | input | 1 | TX stream valid |
| tx_ready | output | 1 | TX stream ready (TX FIFO not full) |
| tx_data | input | 8 | TX frame |
| rx_valid | output | 1 | RX stream valid (RX FIFO not empty) |
| rx_ready | input | 1 | RX stream ready |
| rx_data | output | 8 | RX frame |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_dout | output | 1 | Serial data out |
| spi_din | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low slave select |

## Verification
The bench models the slave as an endless byte stream, so the frames that end up in the RX FIFO show exactly which bit periods were captured. A design that captured during the command phase of mode 3 would return the stream's first bytes instead of the bytes after the command. A design that counted ndf instead of ndf+1 would return one frame too few. The bench also targets:
- a read length of one frame;
- a read that overruns the RX FIFO, where a wrong design would overwrite old frames or leave the flag clear;
- a control write made while enabled, which a faulty design would let change the read length;
- an abort in mid-frame, where a design that kept chip select low until the frame finished would be caught;
- counting the falling edges of chip select, which exposes a design that releases chip select between the command and read phases.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int FRAME_W = 8;

  typedef enum logic [1:0] {
    XM_DUPLEX   = 2'd0,
    XM_TX_ONLY  = 2'd1,
    XM_RX_ONLY  = 2'd2,
    XM_CMD_READ = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SEND  = 2'd1,
    PH_FETCH = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_rd_fifo.sv
module spi_rd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign rd_data = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en && !full)  wp <= wp + 1'b1;
      if (rd_en && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/spi_rd_shifter.sv
module spi_rd_shifter
  import spi_rd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               din,
  output logic               sclk,
  output logic               dout,
  output logic               done,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
  localparam int BW = $clog2(FRAME_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  logic               active;
  logic [CW-1:0]      div_cnt;
  logic [BW-1:0]      bit_cnt;
  logic [FRAME_W-1:0] tx_sh, rx_sh;

  assign dout    = active & tx_sh[FRAME_W-1];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active  <= 1'b0;
        sclk    <= 1'b0;
        div_cnt <= '0;
      end else if (start) begin
        active  <= 1'b1;
        sclk    <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
        tx_sh   <= tx_byte;
      end else if (active) begin
        if (div_cnt == LAST) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[FRAME_W-2:0], din};
          end else begin
            sclk <= 1'b0;
            if (bit_cnt == LAST_BIT) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh   <= {tx_sh[FRAME_W-2:0], 1'b0};
            end
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  xfer_mode_e         mode,
  input  logic [CNT_W-1:0]   count,
  input  logic               tx_empty,
  input  logic [FRAME_W-1:0] tx_head,
  output logic               tx_pop,
  input  logic               sh_done,
  input  logic [FRAME_W-1:0] sh_rx,
  output logic               sh_start,
  output logic [FRAME_W-1:0] sh_byte,
  output logic               sh_abort,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_push_data,
  output logic               busy,
  output logic               cs_n,
  output phase_e             phase
);
  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] left_q, left_n;
  logic             cs_q;

  assign phase        = phase_q;
  assign busy         = (phase_q != PH_IDLE);
  assign cs_n         = cs_q;
  assign sh_abort     = !en && (phase_q != PH_IDLE);
  assign rx_push_data = sh_rx;
  assign rx_push      = sh_done && en &&
                        ((phase_q == PH_FETCH) ||
                         (phase_q == PH_SEND && mode == XM_DUPLEX));

  always_comb begin
    phase_n  = phase_q;
    left_n   = left_q;
    tx_pop   = 1'b0;
    sh_start = 1'b0;
    sh_byte  = tx_head;
    unique case (phase_q)
      PH_IDLE: begin
        if (en && !tx_empty) begin
          tx_pop   = 1'b1;
          sh_start = 1'b1;
          if (mode == XM_RX_ONLY) begin
            sh_byte = '0;
            left_n  = count;
            phase_n = PH_FETCH;
          end else begin
            phase_n = PH_SEND;
          end
        end
      end
      PH_SEND: begin
        if (!en) begin
          phase_n = PH_IDLE;
        end else if (sh_done) begin
          if (!tx_empty) begin
            tx_pop   = 1'b1;
            sh_start = 1'b1;
          end else if (mode == XM_CMD_READ) begin
            sh_start = 1'b1;
            sh_byte  = '0;
            left_n   = count;
            phase_n  = PH_FETCH;
          end else begin
            phase_n = PH_IDLE;
          end
        end
      end
      PH_FETCH: begin
        if (!en) begin
          phase_n = PH_IDLE;
        end else if (sh_done) begin
          if (left_q == '0) begin
            phase_n = PH_IDLE;
          end else begin
            left_n   = left_q - 1'b1;
            sh_start = 1'b1;
            sh_byte  = '0;
          end
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      cs_q    <= 1'b1;
    end else begin
      phase_q <= phase_n;
      left_q  <= left_n;
      cs_q    <= (phase_n == PH_IDLE);
    end
  end
endmodule

// File: rtl/spi_rd_master.sv
module spi_rd_master
  import spi_rd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_en,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_mode,
  input  logic [CNT_W-1:0] ctl_count,
  output logic             stat_busy,
  output logic             stat_rx_ovf,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             spi_sclk,
  output logic             spi_dout,
  input  logic             spi_din,
  output logic             spi_cs_n
);
  logic [1:0]         mode_q;
  logic [CNT_W-1:0]   count_q;
  logic               ovf_q;
  logic               cfg_take;

  logic               tx_full, tx_empty, tx_pop;
  logic [FRAME_W-1:0] tx_head;
  logic               rx_full, rx_empty, rx_push;
  logic [FRAME_W-1:0] rx_push_data;
  logic               sh_start, sh_abort, sh_done;
  logic [FRAME_W-1:0] sh_byte, sh_rx;
  phase_e             phase;

  assign cfg_take    = ctl_wr && !ctl_en;
  assign stat_rx_ovf = ovf_q;
  assign tx_ready    = !tx_full;
  assign rx_valid    = !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'd0;
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (cfg_take) begin
        mode_q  <= ctl_mode;
        count_q <= ctl_count;
      end
      if (cfg_take)                ovf_q <= 1'b0;
      else if (rx_push && rx_full) ovf_q <= 1'b1;
    end
  end

  spi_rd_fifo #(.W(FRAME_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tx_valid), .wr_data(tx_data), .full(tx_full),
    .rd_en(tx_pop), .rd_data(tx_head), .empty(tx_empty)
  );

  spi_rd_fifo #(.W(FRAME_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rx_push), .wr_data(rx_push_data), .full(rx_full),
    .rd_en(rx_ready), .rd_data(rx_data), .empty(rx_empty)
  );

  spi_rd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctl_en),
    .mode(xfer_mode_e'(mode_q)), .count(count_q),
    .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
    .sh_done(sh_done), .sh_rx(sh_rx), .sh_start(sh_start),
    .sh_byte(sh_byte), .sh_abort(sh_abort),
    .rx_push(rx_push), .rx_push_data(rx_push_data),
    .busy(stat_busy), .cs_n(spi_cs_n), .phase(phase)
  );

  spi_rd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .abort(sh_abort), .start(sh_start),
    .tx_byte(sh_byte), .din(spi_din), .sclk(spi_sclk), .dout(spi_dout),
    .done(sh_done), .rx_byte(sh_rx)
  );
endmodule

// File: rtl/spi_rd_master_chk.sv
module spi_rd_master_chk
  import spi_rd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_en,
  input logic       ctl_wr,
  input logic       cs_n,
  input logic       sclk,
  input logic       dout,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       ovf,
  input logic [1:0] mode,
  input logic [1:0] phase
);
  assert_cfg_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ctl_wr) |=> $stable(mode));

  assert_cs_high_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> cs_n);

  assert_rxonly_dout_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'(XM_RX_ONLY) && !cs_n) |-> !dout);

  assert_fetch_dout_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'(XM_CMD_READ) && phase == 2'(PH_FETCH)) |-> !dout);

  assert_sclk_under_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(ctl_wr && !ctl_en)) |=> ovf);

  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_rd_master spi_rd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_wr(ctl_wr),
  .cs_n(spi_cs_n), .sclk(spi_sclk), .dout(spi_dout),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .ovf(stat_rx_ovf), .mode(mode_q), .phase(phase)
);

// File: tb/spi_rd_master_tb.sv
`timescale 1ns/1ps
module spi_rd_master_tb;
  localparam int CW   = 8;
  localparam int RXD  = 8;
  localparam int TMAX = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ctl_en = 0, ctl_wr = 0;
  logic [1:0]    ctl_mode = 0;
  logic [CW-1:0] ctl_count = 0;
  logic          stat_busy, stat_rx_ovf;
  logic          tx_valid = 0, tx_ready;
  logic [7:0]    tx_data = 0;
  logic          rx_valid, rx_ready = 0;
  logic [7:0]    rx_data;
  logic          spi_sclk, spi_dout, spi_cs_n;
  logic          spi_din = 1'b0;

  spi_rd_master #(.HALF_DIV(2), .TX_DEPTH(8), .RX_DEPTH(RXD), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_wr(ctl_wr),
    .ctl_mode(ctl_mode), .ctl_count(ctl_count), .stat_busy(stat_busy),
    .stat_rx_ovf(stat_rx_ovf), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .spi_sclk(spi_sclk), .spi_dout(spi_dout),
    .spi_din(spi_din), .spi_cs_n(spi_cs_n)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(input int base, input int i);
    return 8'(base + i * 53 + 17);
  endfunction

  function automatic logic rbit(input int base, input int k);
    logic [7:0] b;
    b = rbyte(base, k / 8);
    return b[7 - (k % 8)];
  endfunction

  // Slave model: endless response stream, MOSI capture on rising sclk
  int         sl_bit = 0, sl_falls = 0, mosi_n = 0, sl_base = 0;
  logic [7:0] mosi_sh = 0;
  logic [7:0] mosi_log [0:63];

  always @(negedge spi_cs_n) begin
    sl_bit = 0;
    mosi_n = 0;
    sl_falls++;
    spi_din = rbit(sl_base, 0);
  end

  always @(posedge spi_sclk) begin
    mosi_sh = {mosi_sh[6:0], spi_dout};
    sl_bit++;
    if (sl_bit % 8 == 0) begin
      if (mosi_n < 64) mosi_log[mosi_n] = mosi_sh;
      mosi_n++;
    end
  end

  always @(negedge spi_sclk) spi_din = rbit(sl_base, sl_bit);

  logic [7:0] tx_b [0:15];
  int falls0 = 0;

  task automatic cfg(input int mode, input int ndf);
    @(negedge clk);
    ctl_wr = 1; ctl_mode = 2'(mode); ctl_count = CW'(ndf);
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic push(input logic [7:0] b);
    tx_data = b; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      tx_b[i] = 8'($urandom);
      push(tx_b[i]);
    end
  endtask

  task automatic wait_done();
    int t = 0, mism = 0;
    while (spi_cs_n && t < 2000) begin @(negedge clk); t++; end
    while (!spi_cs_n && t < 20000) begin
      if (stat_busy == spi_cs_n) mism++;
      @(negedge clk); t++;
    end
    chk(t < 20000, "R7", "chip select released", t, 20000);
    chk(mism == 0, "R10", "busy tracks chip select", mism, 0);
    chk(!stat_busy, "R10", "busy low after release", stat_busy, 0);
  endtask

  task automatic drain(input int exp_n, input int idx, input bit rnd, input string req);
    int got = 0;
    for (int c = 0; c < 120; c++) begin
      rx_ready = rnd ? 1'($urandom % 2) : 1'b1;
      if (rx_valid && rx_ready) begin
        chk(rx_data == rbyte(sl_base, idx + got), req, "received frame",
            rx_data, rbyte(sl_base, idx + got));
        got++;
      end
      @(negedge clk);
    end
    rx_ready = 0;
    chk(got == exp_n, req, "received frame count (R11 stream)", got, exp_n);
  endtask

  task automatic verify(input int mode, input int ncmd, input int ndf, input bit rnd);
    string rq;
    int nsent, total, nrx, idx, keep;
    rq    = (mode == 0) ? "R3" : (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R6";
    nsent = (mode == 2) ? 0 : ncmd;
    total = (mode == 2) ? ndf + 1 : (mode == 3) ? ncmd + ndf + 1 : ncmd;
    nrx   = (mode == 0) ? ncmd : (mode == 1) ? 0 : ndf + 1;
    idx   = (mode == 3) ? ncmd : 0;
    keep  = (nrx > RXD) ? RXD : nrx;
    chk(mosi_n == total, rq, "frames on the wire", mosi_n, total);
    for (int i = 0; i < total && i < 64; i++) begin
      int e;
      e = (i < nsent) ? int'(tx_b[i]) : 0;
      chk(int'(mosi_log[i]) == e, rq, "sent frame, MSB first on falling edges (R8)",
          mosi_log[i], e);
    end
    chk(sl_falls - falls0 == 1, "R7", "chip select falls once", sl_falls - falls0, 1);
    chk(stat_rx_ovf == (nrx > RXD), "R9", "overflow flag", stat_rx_ovf, int'(nrx > RXD));
    drain(keep, idx, rnd, rq);
  endtask

  task automatic run(input int mode, input int ncmd, input int ndf, input bit rnd);
    cfg(mode, ndf);
    chk(!stat_rx_ovf, "R9", "overflow cleared by control write (R1)", stat_rx_ovf, 0);
    load((mode == 2) ? 1 : ncmd);
    sl_base = int'($urandom % 256);
    falls0 = sl_falls;
    ctl_en = 1;
    wait_done();
    ctl_en = 0;
    verify(mode, (mode == 2) ? 1 : ncmd, ndf, rnd);
  endtask

  initial begin
    #(TMAX * 5.0);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(spi_cs_n == 1, "R2", "reset chip select", spi_cs_n, 1);
    chk(spi_sclk == 0, "R8", "reset sclk idle low", spi_sclk, 0);
    chk(stat_busy == 0, "R10", "reset busy", stat_busy, 0);
    chk(rx_valid == 0, "R11", "reset rx empty", rx_valid, 0);
    chk(tx_ready == 1, "R11", "reset tx ready", tx_ready, 1);
    chk(stat_rx_ovf == 0, "R11", "reset overflow", stat_rx_ovf, 0);

    run(3, 3, 3, 0);
    run(0, 4, 0, 1);
    run(1, 3, 0, 0);
    run(2, 1, 4, 1);
    run(3, 1, 0, 0);
    run(3, 2, 9, 0);   // 10 read frames into an 8-deep RX FIFO
    run(1, 1, 0, 0);   // control write clears overflow

    // R1: control write while enabled is ignored
    cfg(3, 1);
    sl_base = int'($urandom % 256);
    falls0 = sl_falls;
    ctl_en = 1;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1, "R2", "chip select high while idle and enabled", spi_cs_n, 1);
    ctl_wr = 1; ctl_mode = 2'd1; ctl_count = CW'(5);
    @(negedge clk);
    ctl_wr = 0;
    load(2);
    wait_done();
    ctl_en = 0;
    verify(3, 2, 1, 0);

    // R2: abort in mid-transfer
    cfg(0, 0);
    load(6);
    ctl_en = 1;
    while (spi_cs_n) @(negedge clk);
    repeat (45) @(negedge clk);
    ctl_en = 0;
    @(negedge clk);
    chk(spi_cs_n == 1, "R2", "chip select after abort", spi_cs_n, 1);
    chk(stat_busy == 0, "R2", "busy after abort", stat_busy, 0);
    chk(spi_sclk == 0, "R2", "sclk after abort", spi_sclk, 0);
    rx_ready = 1; repeat (12) @(negedge clk); rx_ready = 0;
    cfg(1, 0);
    ctl_en = 1;
    wait_done();
    ctl_en = 0;
    rx_ready = 1; repeat (12) @(negedge clk); rx_ready = 0;

    for (int it = 0; it < 14; it++) begin
      int m, n, d;
      m = int'($urandom % 4);
      n = (m == 2) ? 1 : 1 + int'($urandom % 5);
      d = int'($urandom % 7);
      run(m, n, d, 1'($urandom % 2));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule